// File: doc/BRIEF.md
# Strobed Input Port Handshake

This block is a parallel input port with a handshake. An external device puts a byte on the data inputs and pulses an active-low strobe. When the strobe returns high, the port holds that byte and raises a buffer-full flag. If the interrupt enable is set, it also raises an interrupt request. The CPU reads the byte through a synchronous, active-low read strobe. That read clears both the flag and the interrupt request.

The device side is asynchronous to the system clock. The strobe goes through a two-flop synchroniser, and the rising edge of the synchronised strobe is the capture event. The data bus is delayed through a matching register pipeline. The byte captured is therefore the one sampled while the strobe was still low, and the device does not need to hold data after the strobe rises. Reset is asynchronous and active low, and it is released on a clock edge through a local reset synchroniser.

Top module: `strobed_in_port`

## Requirements
- R1: While reset is asserted and after it is released, buf_full is 0, irq is 0 and cpu_rdata is 0.
- R2: A byte held on dev_data while dev_stb_n is low is latched on the third rising clock edge after dev_stb_n returns high. buf_full is still unchanged after the second of those edges.
- R3: buf_full stays 1 until a rising edge at which cpu_rd_n is 0. That edge clears it.
- R4: cpu_rdata always shows the latched byte. It does not change when dev_data changes without a strobe, and it does not change on a CPU read.
- R5: If int_en is 1 at the capture edge, irq rises at the same edge as buf_full. If int_en is 0 at that edge, irq stays 0.
- R6: A CPU read (cpu_rd_n 0 at a rising edge) clears irq at that edge.
- R7: int_en at 0 forces irq to 0 after the next rising edge and leaves buf_full and cpu_rdata unchanged. Setting int_en back to 1 does not raise irq again until the next capture.
- R8: A strobe that completes while buf_full is 1 overwrites the latched byte. buf_full stays 1, and irq is set if int_en is 1.
- R9: When a capture and a CPU read fall on the same rising edge, the capture wins. buf_full ends at 1, holding the new byte.
- R10: Each strobe pulse gives exactly one capture, however long it is held low. Nothing is latched while the strobe is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_data | input | 8 | Byte from the external device |
| dev_stb_n | input | 1 | Active-low capture strobe from the device, asynchronous |
| int_en | input | 1 | Interrupt enable |
| cpu_rd_n | input | 1 | Active-low CPU read strobe, sampled on clk |
| cpu_rdata | output | 8 | Latched byte |
| buf_full | output | 1 | Buffer-full flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong synchroniser depth or a wrong edge detector changes the latency of buf_full. It then rises one edge early or late, or twice for one long pulse, and this shows within three clocks of the strobe. A fault in the capture register shows as a wrong byte on cpu_rdata, or as a byte that changes with no strobe. This is visible on the first compare after the strobe. A fault in the read clear, the enable gating or the priority between capture and read leaves buf_full or irq at the wrong level. This shows on the clock edge that follows the read or the enable change.

// File: rtl/sip_pkg.sv
package sip_pkg;
  localparam int unsigned SIP_DATA_W_DEF = 8;
  localparam int unsigned SIP_SYNC_DEF   = 2;

  // idle level of the device strobe and its delayed copies
  localparam logic SIP_STB_IDLE = 1'b1;

  typedef enum logic [1:0] {
    BUF_KEEP  = 2'd0,
    BUF_LOAD  = 2'd1,
    BUF_CLEAR = 2'd2
  } buf_act_e;
endpackage

// File: rtl/sip_rst_sync.sv
module sip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/sip_strobe_sync.sv
module sip_strobe_sync
  import sip_pkg::*;
#(
  parameter int unsigned DATA_W = SIP_DATA_W_DEF,
  parameter int unsigned STAGES = SIP_SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              cap_o,
  output logic [DATA_W-1:0] cap_data_o
);
  localparam int unsigned DLY = STAGES + 1;

  logic [STAGES-1:0] stb_q;
  logic              stb_prev_q;
  logic              stb_prev_d;
  logic [DATA_W-1:0] dpipe_q [DLY];

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stb
    logic nxt;
    if (g == 0) begin : g_first
      assign nxt = stb_n_i;
    end else begin : g_rest
      assign nxt = stb_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q[g] <= SIP_STB_IDLE;
      else        stb_q[g] <= nxt;
    end
  end

  for (g = 0; g < DLY; g++) begin : g_dat
    logic [DATA_W-1:0] nxt;
    if (g == 0) begin : g_first
      assign nxt = data_i;
    end else begin : g_rest
      assign nxt = dpipe_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dpipe_q[g] <= '0;
      else        dpipe_q[g] <= nxt;
    end
  end

  always_comb begin
    stb_prev_d = stb_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_prev_q <= SIP_STB_IDLE;
    else        stb_prev_q <= stb_prev_d;
  end

  // rising edge of the synchronised strobe; the delayed byte was sampled while it was low
  assign cap_o      = stb_q[STAGES-1] & ~stb_prev_q;
  assign cap_data_o = dpipe_q[STAGES];

  // R10: one capture per pulse
  p_single_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> !cap_o);
endmodule

// File: rtl/sip_buffer.sv
module sip_buffer
  import sip_pkg::*;
#(
  parameter int unsigned DATA_W = SIP_DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              rd_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  buf_act_e          act;
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    if (cap_i)     act = BUF_LOAD;   // capture has priority over a read
    else if (rd_i) act = BUF_CLEAR;
    else           act = BUF_KEEP;
  end

  always_comb begin
    full_d  = full_q;
    data_en = 1'b0;
    data_d  = cap_data_i;
    unique case (act)
      BUF_LOAD:  begin full_d = 1'b1; data_en = 1'b1; end
      BUF_CLEAR: full_d = 1'b0;
      default:   full_d = full_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign full_o = full_q;
  assign data_o = data_q;

  p_hold_until_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> $past(rd_i));
  p_data_only_on_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(data_q));
  p_cap_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> full_q);
endmodule

// File: rtl/sip_irq.sv
module sip_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_i,
  input  logic rd_i,
  input  logic en_i,
  output logic irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    if (cap_i && en_i)      irq_d = 1'b1;
    else if (rd_i || !en_i) irq_d = 1'b0;
    else                    irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  p_irq_on_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && en_i) |=> irq_q);
  p_read_clears_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !cap_i) |=> !irq_q);
  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !irq_q);
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
  import sip_pkg::*;
#(
  parameter int unsigned DATA_W = SIP_DATA_W_DEF,
  parameter int unsigned SYNC   = SIP_SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              dev_stb_n,
  input  logic              int_en,
  input  logic              cpu_rd_n,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              buf_full,
  output logic              irq
);
  logic              srst_n;
  logic              cap;
  logic [DATA_W-1:0] cap_data;
  logic              rd;

  assign rd = ~cpu_rd_n;

  sip_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  sip_strobe_sync #(.DATA_W(DATA_W), .STAGES(SYNC)) u_sync (
    .clk        (clk),
    .rst_n      (srst_n),
    .stb_n_i    (dev_stb_n),
    .data_i     (dev_data),
    .cap_o      (cap),
    .cap_data_o (cap_data)
  );

  sip_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (srst_n),
    .cap_i      (cap),
    .cap_data_i (cap_data),
    .rd_i       (rd),
    .full_o     (buf_full),
    .data_o     (cpu_rdata)
  );

  sip_irq u_irq (
    .clk   (clk),
    .rst_n (srst_n),
    .cap_i (cap),
    .rd_i  (rd),
    .en_i  (int_en),
    .irq_o (irq)
  );

  // R5: an interrupt only ever accompanies a full buffer
  p_irq_implies_full_r5: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> buf_full);
  // R2: the flag only rises from a detected strobe edge
  p_full_from_edge_r2: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(buf_full) |-> $past(cap));
endmodule

// File: tb/strobed_in_port_test.sv
module strobed_in_port_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic [7:0] dev_data;
  logic       dev_stb_n;
  logic       int_en;
  logic       cpu_rd_n;
  logic [7:0] cpu_rdata;
  logic       buf_full;
  logic       irq;

  int n_checks;
  int n_fail;
  bit done;

  logic       m_full;
  logic       m_irq;
  logic [7:0] m_data;

  strobed_in_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_data  (dev_data),
    .dev_stb_n (dev_stb_n),
    .int_en    (int_en),
    .cpu_rd_n  (cpu_rd_n),
    .cpu_rdata (cpu_rdata),
    .buf_full  (buf_full),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // expected interrupt after a capture edge
  function automatic logic exp_irq_cap(input logic en);
    return en;
  endfunction
  // expected interrupt after an enable change
  function automatic logic exp_irq_en(input logic en, input logic cur);
    return en ? cur : 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " full"}, buf_full, m_full);
    check({req, " irq"},  irq,      m_irq);
    check({req, " data"}, cpu_rdata, m_data);
  endtask

  // drive a strobe pulse and stop at the negedge after the capture edge
  task automatic strobe(input logic [7:0] d, input int low_cycles);
    @(negedge clk);
    dev_data  = d;
    dev_stb_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    dev_stb_n = 1'b1;
    repeat (3) @(negedge clk);
    m_full = 1'b1;
    m_data = d;
    m_irq  = exp_irq_cap(int_en);
    dev_data = 8'($urandom);
  endtask

  task automatic cpu_read();
    @(negedge clk);
    cpu_rd_n = 1'b0;
    @(negedge clk);
    cpu_rd_n = 1'b1;
    m_full = 1'b0;
    m_irq  = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    int_en = v;
    @(negedge clk);
    m_irq = exp_irq_en(v, m_irq);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; dev_data = 8'hA5; dev_stb_n = 1'b1; int_en = 1'b0; cpu_rd_n = 1'b1;
    m_full = 1'b0; m_irq = 1'b0; m_data = 8'h00;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R1 after reset");

    // R10: long low strobe latches nothing until release
    int_en = 1'b1;
    @(negedge clk);
    dev_data = 8'h3C; dev_stb_n = 1'b0;
    repeat (12) @(negedge clk);
    check("R10 nothing while low", buf_full, 1'b0);
    dev_stb_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 not yet after two edges", buf_full, 1'b0);
    @(negedge clk);
    m_full = 1'b1; m_data = 8'h3C; m_irq = 1'b1;
    check_all("R2 R5 capture on third edge");
    dev_data = 8'hFF;
    repeat (6) @(negedge clk);
    check_all("R10 R4 R3 single capture, held");
    cpu_read();
    check_all("R3 R6 R4 read clears");

    // R5: capture with interrupts disabled
    set_en(1'b0);
    strobe(8'h81, 2);
    check_all("R5 no irq when disabled");
    cpu_read();

    // R7: disable after irq, then re-enable
    set_en(1'b1);
    strobe(8'h42, 3);
    check_all("R7 irq set");
    set_en(1'b0);
    check_all("R7 irq forced low, full kept");
    set_en(1'b1);
    check_all("R7 re-enable no irq");

    // R8: overwrite while full
    strobe(8'h99, 2);
    check_all("R8 overwrite");

    // R9: read on the capture edge
    @(negedge clk);
    dev_data = 8'h17; dev_stb_n = 1'b0;
    repeat (3) @(negedge clk);
    dev_stb_n = 1'b1;
    repeat (2) @(negedge clk);
    cpu_rd_n = 1'b0;
    @(negedge clk);
    cpu_rd_n = 1'b1;
    m_full = 1'b1; m_data = 8'h17; m_irq = 1'b1;
    check_all("R9 capture wins");
    cpu_read();
    check_all("R9 R3 later read clears");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int unsigned op;
      op = $urandom_range(0, 3);
      case (op)
        0, 1: begin
          strobe(8'($urandom), int'($urandom_range(1, 5)));
          check_all("R2 R8 random strobe");
        end
        2: begin
          cpu_read();
          check_all("R3 R6 random read");
        end
        default: begin
          set_en(1'($urandom));
          check_all("R7 random enable");
        end
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule